// File: doc/BRIEF.md
# Two-Phase Track Packet Receiver

This block decodes packets from a single-wire serial bus such as the data line of a digital slot-car track. The line idles high. A falling edge starts a packet, and that edge also serves as the low first half of bit 0. From that edge on, a fast sampling tick reads the line once per half-bit, so each bit gets two samples. The second sample of a bit gives the bit's value. A pair of samples that are both high marks the end of the packet, so packets can have any length. When a packet ends, the block presents its data, its bit count and a flag that marks sync packets, together with a one-cycle valid strobe.

Each packet end opens a short reply window, measured with a coarse idle counter. A falling edge that arrives inside this window is taken as the possible start of a slower reply burst from a device on the track. If the line is high again one fast period later, the block samples the burst by level, once per slow tick. It reports the burst on a second set of outputs with its own strobe. The raw line is synchronised on entry. All three tick periods are parameters given in system clock cycles.

Top module: `trk_pkt_rx`

## Requirements
- R1: While reset is high, both strobes are 0, all data and length outputs are 0, and pkt_sync is 0. The idle counter is reset to its saturated value of 255, so the first falling edge after reset always starts a packet.
- R2: The line passes through a two-flop synchroniser, and edges are detected after it. In the idle state, a falling edge outside the reply window starts a packet. That edge stands for a low first half of bit 0. The line is then sampled every FAST_DIV cycles, and the first sample falls FAST_DIV cycles after the edge is detected.
- R3: For each bit, the first sample is only stored. Unless the packet ends, the second sample shifts into the data register at the LSB, MSB first: a low second sample gives 1 and a high one gives 0. Each such bit adds one to the bit count.
- R4: When the stored first sample and the second sample are both high, the packet ends. pkt_valid is then high for one cycle, with pkt_data holding the low 16 bits shifted in and pkt_len holding the bit count modulo 32. These outputs hold their values until the next packet ends.
- R5: pkt_sync is 1 exactly when the reported pkt_len is 13. It is updated together with pkt_len.
- R6: At every packet end, the idle counter clears to 0. After that, it goes up by one every COARSE_DIV cycles and saturates at 255.
- R7: A falling edge seen while the idle counter is between 1 and 9 inclusive is a reply candidate. The block samples the line once, FAST_DIV cycles later. If the line is high, reply reception starts. If it is low, the candidate is dropped and the block returns to idle without starting a packet.
- R8: In reply reception, the line is sampled every REPLY_DIV cycles by level (high gives 1), and the first sample comes REPLY_DIV cycles after acceptance. After 15 samples, rpl_valid is high for one cycle. rpl_data then holds the samples in bits 14 down to 0, first sample in bit 14, with bit 15 at 0, and rpl_len is 15.
- R9: Falling edges that arrive while a packet, a candidate check or a reply is being sampled are ignored and are not queued.
- R10: pkt_valid and rpl_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw serial track line, idle high |
| pkt_data | output | 16 | Data bits of the last packet, last bit in bit 0 |
| pkt_len | output | 5 | Bit count of the last packet |
| pkt_sync | output | 1 | Last packet had exactly 13 bits |
| pkt_valid | output | 1 | One-cycle strobe at packet end |
| rpl_data | output | 16 | Last reply burst, first sample in bit 14 |
| rpl_len | output | 5 | Number of reply samples |
| rpl_valid | output | 1 | One-cycle strobe at reply end |

## Verification
Two things can land on the same clock edge: the step of the idle counter from 9 to 10, and the detection of a new falling edge. Whether the edge opens a reply or a packet depends on which value the edge sees. The bench places the detection edge exactly one cycle either side of both window limits, measured from the cycle in which pkt_valid is seen. It then judges the outcome from which strobe follows: a one-bit packet with data 0, or a reply of all ones. A cycle-by-cycle model based on absolute sample times backs this up on every clock.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int DATA_W     = 16;
    localparam int LEN_W      = 5;
    localparam int IDLE_W     = 8;
    localparam int SYNC_LEN   = 13;
    localparam int REPLY_BITS = 15;
    localparam int WIN_LO     = 1;
    localparam int WIN_HI     = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PKT,
        ST_CHK,
        ST_RPL
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  cnt;
        logic              first;
        logic              half;
    } pkt_acc_t;

    function automatic logic in_window(input logic [IDLE_W-1:0] c);
        return (c >= IDLE_W'(WIN_LO)) && (c <= IDLE_W'(WIN_HI));
    endfunction

endpackage

// File: rtl/trk_line_sync.sv
module trk_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[1:0], line_i};
    end

    assign lvl_o  = sh[1];
    assign fall_o = sh[2] & ~sh[1];
endmodule

// File: rtl/trk_tick_div.sv
module trk_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic en,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick_o = en && !restart && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (en)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/trk_pkt_rx.sv
module trk_pkt_rx
    import trk_pkg::*;
#(
    parameter int FAST_DIV   = 12500,
    parameter int REPLY_DIV  = 62500,
    parameter int COARSE_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic [DATA_W-1:0] pkt_data,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_sync,
    output logic              pkt_valid,
    output logic [DATA_W-1:0] rpl_data,
    output logic [LEN_W-1:0]  rpl_len,
    output logic              rpl_valid
);
    logic lvl, fall;
    logic f_tick, r_tick, c_tick;
    logic go_pkt, go_chk, go_rpl, pkt_done, rpl_last;

    rx_state_t         st;
    pkt_acc_t          acc;
    logic [DATA_W-1:0] rsh;
    logic [LEN_W-1:0]  rcnt;
    logic [IDLE_W-1:0] idle_cnt;

    trk_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .line_i(line_i),
        .lvl_o (lvl),
        .fall_o(fall)
    );

    always_comb begin
        go_pkt   = (st == ST_IDLE) && fall && !in_window(idle_cnt);
        go_chk   = (st == ST_IDLE) && fall &&  in_window(idle_cnt);
        go_rpl   = (st == ST_CHK) && f_tick && lvl;
        pkt_done = (st == ST_PKT) && f_tick && acc.half && acc.first && lvl;
        rpl_last = (st == ST_RPL) && r_tick && (rcnt == LEN_W'(REPLY_BITS - 1));
    end

    trk_tick_div #(.DIV(FAST_DIV)) u_fast (
        .clk    (clk),
        .rst    (rst),
        .restart(go_pkt || go_chk),
        .en     ((st == ST_PKT) || (st == ST_CHK)),
        .tick_o (f_tick)
    );

    trk_tick_div #(.DIV(REPLY_DIV)) u_slow (
        .clk    (clk),
        .rst    (rst),
        .restart(go_rpl),
        .en     (st == ST_RPL),
        .tick_o (r_tick)
    );

    trk_tick_div #(.DIV(COARSE_DIV)) u_coarse (
        .clk    (clk),
        .rst    (rst),
        .restart(pkt_done),
        .en     (1'b1),
        .tick_o (c_tick)
    );

    // idle counter: packet end clears, coarse tick counts, saturates
    always_ff @(posedge clk) begin
        if (rst)                              idle_cnt <= '1;
        else if (pkt_done)                    idle_cnt <= '0;
        else if (c_tick && (idle_cnt != '1))  idle_cnt <= idle_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            acc       <= '0;
            rsh       <= '0;
            rcnt      <= '0;
            pkt_data  <= '0;
            pkt_len   <= '0;
            pkt_sync  <= 1'b0;
            pkt_valid <= 1'b0;
            rpl_data  <= '0;
            rpl_len   <= '0;
            rpl_valid <= 1'b0;
        end else begin
            pkt_valid <= 1'b0;
            rpl_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go_pkt) begin
                        st  <= ST_PKT;
                        acc <= '{data: '0, cnt: '0, first: 1'b0, half: 1'b1};
                    end else if (go_chk) begin
                        st <= ST_CHK;
                    end
                end
                ST_PKT: begin
                    if (f_tick) begin
                        if (!acc.half) begin
                            acc.first <= lvl;
                            acc.half  <= 1'b1;
                        end else begin
                            acc.half <= 1'b0;
                            if (pkt_done) begin
                                pkt_data  <= acc.data;
                                pkt_len   <= acc.cnt;
                                pkt_sync  <= (acc.cnt == LEN_W'(SYNC_LEN));
                                pkt_valid <= 1'b1;
                                st        <= ST_IDLE;
                            end else begin
                                acc.data <= {acc.data[DATA_W-2:0], ~lvl};
                                acc.cnt  <= acc.cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_CHK: begin
                    if (f_tick) begin
                        if (lvl) begin
                            st   <= ST_RPL;
                            rsh  <= '0;
                            rcnt <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_RPL: begin
                    if (r_tick) begin
                        rsh  <= {rsh[DATA_W-2:0], lvl};
                        rcnt <= rcnt + 1'b1;
                        if (rpl_last) begin
                            rpl_data  <= {rsh[DATA_W-2:0], lvl};
                            rpl_len   <= LEN_W'(REPLY_BITS);
                            rpl_valid <= 1'b1;
                            st        <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: packet strobe lasts one cycle
    a_r4_pkt_pulse: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid);

    // R8: reply strobe lasts one cycle and carries a fixed length
    a_r8_rpl_pulse: assert property (@(posedge clk) disable iff (rst)
        rpl_valid |=> !rpl_valid);
    a_r8_rpl_len: assert property (@(posedge clk) disable iff (rst)
        rpl_valid |-> (rpl_len == LEN_W'(REPLY_BITS)) && !rpl_data[DATA_W-1]);

    // R10: the two strobes are exclusive
    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && rpl_valid));

    // R6: idle counter sits at zero when a packet is reported, and stays saturated
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (idle_cnt == '0));
    a_r6_sat: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt == '1) |=> ((idle_cnt == '1) || (idle_cnt == '0)));

    // R9: nothing but a sample tick moves the packet state on
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_PKT) && !f_tick) |=> (st == ST_PKT));

    // R7: a low check sample drops the candidate without a packet
    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_CHK) && f_tick && !lvl) |=> ((st == ST_IDLE) && !pkt_valid));
endmodule

// File: tb/sim_trk_pkt_rx.sv
module sim_trk_pkt_rx;
    localparam int F = 4;
    localparam int R = 12;
    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic [15:0] pkt_data, rpl_data;
    logic [4:0]  pkt_len, rpl_len;
    logic        pkt_sync, pkt_valid, rpl_valid;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit finished = 0;

    logic [21:0] pkt_q[$];
    logic [20:0] rpl_q[$];

    always #2 clk = ~clk;

    trk_pkt_rx #(.FAST_DIV(F), .REPLY_DIV(R), .COARSE_DIV(C)) u0 (
        .clk(clk), .rst(rst), .line_i(line),
        .pkt_data(pkt_data), .pkt_len(pkt_len), .pkt_sync(pkt_sync), .pkt_valid(pkt_valid),
        .rpl_data(rpl_data), .rpl_len(rpl_len), .rpl_valid(rpl_valid)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model on absolute sample times ----------------
    int n = 0, mode = 0, next_t = 0, last_done = -1;
    int md = 0, mc = 0, rd = 0, rc = 0, iv = 0;
    bit h1 = 1, h2 = 1, h3 = 1, half = 0, first = 0, lv = 0, fl = 0;
    int e_pd = 0, e_pl = 0, e_rd = 0, e_rl = 0;
    bit e_ps = 0, e_pv = 0, e_rv = 0;

    always @(posedge clk) begin
        n++;
        started = 1;
        if (rst) begin
            mode = 0; last_done = -1; h1 = 1; h2 = 1; h3 = 1;
            e_pd = 0; e_pl = 0; e_ps = 0; e_pv = 0; e_rd = 0; e_rl = 0; e_rv = 0;
        end else begin
            lv = h2;
            fl = h3 && !h2;
            if (last_done < 0) iv = 255;
            else begin
                iv = (n - 1 - last_done) / C;
                if (iv > 255) iv = 255;
            end
            e_pv = 0;
            e_rv = 0;
            case (mode)
                0: if (fl) begin
                    next_t = n + F;
                    if (iv >= 1 && iv <= 9) mode = 2;
                    else begin mode = 1; md = 0; mc = 0; half = 1; first = 0; end
                end
                1: if (n == next_t) begin
                    next_t = n + F;
                    if (!half) begin first = lv; half = 1; end
                    else begin
                        half = 0;
                        if (first && lv) begin
                            e_pv = 1; e_pd = md; e_pl = mc % 32; e_ps = (mc % 32 == 13);
                            last_done = n; mode = 0;
                        end else begin
                            md = ((md << 1) | (lv ? 0 : 1)) & 16'hFFFF;
                            mc++;
                        end
                    end
                end
                2: if (n == next_t) begin
                    if (lv) begin mode = 3; next_t = n + R; rd = 0; rc = 0; end
                    else mode = 0;
                end
                default: if (n == next_t) begin
                    next_t = n + R;
                    rd = ((rd << 1) | (lv ? 1 : 0)) & 16'hFFFF;
                    rc++;
                    if (rc == 15) begin e_rv = 1; e_rd = rd; e_rl = 15; mode = 0; end
                end
            endcase
            h3 = h2; h2 = h1; h1 = line;
        end
    end

    // every-clock comparison and event capture
    always @(negedge clk) begin
        if (started) begin
            chk(pkt_valid === e_pv && pkt_data === e_pd[15:0] && pkt_len === e_pl[4:0],
                "R4", "pkt outputs", {pkt_valid, pkt_len, pkt_data}, {e_pv, e_pl[4:0], e_pd[15:0]});
            chk(pkt_sync === e_ps, "R5", "pkt_sync", pkt_sync, e_ps);
            chk(rpl_valid === e_rv && rpl_data === e_rd[15:0] && rpl_len === e_rl[4:0],
                "R8", "reply outputs", {rpl_valid, rpl_len, rpl_data}, {e_rv, e_rl[4:0], e_rd[15:0]});
            chk(!(pkt_valid && rpl_valid), "R10", "strobe overlap", {pkt_valid, rpl_valid}, 0);
            if (pkt_valid) pkt_q.push_back({pkt_sync, pkt_len, pkt_data});
            if (rpl_valid) rpl_q.push_back({rpl_len, rpl_data});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [31:0] v, input int nb);
        line = 1'b0;
        repeat (F) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            logic b;
            b = v[nb-1-i];
            if (i > 0) begin
                line = b;
                repeat (F) @(negedge clk);
            end
            line = !b;
            repeat (F) @(negedge clk);
        end
        line = 1'b1;
    endtask

    task automatic wait_done();
        while (!pkt_valid) @(negedge clk);
    endtask

    // called at the negedge after the packet-end edge; edge is detected K edges later
    task automatic reply_at(input int k, input logic [14:0] v, input bit hold_low);
        repeat (k - 3) @(negedge clk);
        line = 1'b0;
        if (hold_low) begin
            repeat (2 * F) @(negedge clk);
            line = 1'b1;
        end else begin
            repeat (2) @(negedge clk);
            line = 1'b1;
            repeat (F + R / 2 - 2) @(negedge clk);
            for (int i = 14; i >= 0; i--) begin
                line = v[i];
                repeat (R) @(negedge clk);
            end
            line = 1'b1;
        end
    endtask

    task automatic expect_pkt(input int d, input int l, input bit s, input string req);
        logic [21:0] e;
        chk(pkt_q.size() > 0, req, "packet present", pkt_q.size(), 1);
        if (pkt_q.size() > 0) begin
            e = pkt_q.pop_front();
            chk(e[15:0] == d[15:0], req, "pkt_data", e[15:0], d[15:0]);
            chk(e[20:16] == l[4:0], req, "pkt_len", e[20:16], l[4:0]);
            chk(e[21] == s, "R5", "pkt_sync", e[21], s);
        end
    endtask

    task automatic expect_rpl(input int d, input string req);
        logic [20:0] e;
        chk(rpl_q.size() > 0, req, "reply present", rpl_q.size(), 1);
        if (rpl_q.size() > 0) begin
            e = rpl_q.pop_front();
            chk(e[15:0] == d[15:0], req, "rpl_data", e[15:0], d[15:0]);
            chk(e[20:16] == 5'd15, "R8", "rpl_len", e[20:16], 15);
        end
    endtask

    task automatic expect_none(input string req);
        chk(pkt_q.size() == 0, req, "no extra packet", pkt_q.size(), 0);
        chk(rpl_q.size() == 0, req, "no extra reply", rpl_q.size(), 0);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        idle(3);
        // R1: reset state
        chk(pkt_valid == 0 && rpl_valid == 0, "R1", "strobes in reset", {pkt_valid, rpl_valid}, 0);
        chk(pkt_data == 0 && pkt_len == 0 && pkt_sync == 0, "R1", "pkt outputs in reset", pkt_data, 0);
        chk(rpl_data == 0 && rpl_len == 0, "R1", "reply outputs in reset", rpl_data, 0);
        rst = 1'b0;
        idle(5);

        // R1/R2/R3/R5: first edge after reset is a packet; 13 bits is sync
        send_pkt(32'h1A5B, 13); wait_done(); idle(2);
        expect_pkt(16'h1A5B, 13, 1'b1, "R3");
        idle(11 * C);

        // R3/R4: short packet, then a back-to-back one with idle count 0 (R6)
        send_pkt(32'h00C3, 8); wait_done();
        send_pkt(32'h0005, 3); wait_done(); idle(2);
        expect_pkt(16'h00C3, 8, 1'b0, "R4");
        expect_pkt(16'h0005, 3, 1'b0, "R6");
        idle(11 * C);

        // R4: long packet keeps low 16 bits, count 20
        send_pkt(32'hABCDE, 20); wait_done(); idle(2);
        expect_pkt(16'hBCDE, 20, 1'b0, "R4");
        idle(11 * C);

        // R8/R9: reply inside window with a mixed pattern
        send_pkt(32'h0F0F, 13); wait_done();
        reply_at(4 * C, 15'h5A3C, 1'b0); idle(10);
        expect_pkt(16'h0F0F, 13, 1'b1, "R4");
        expect_rpl(16'h5A3C, "R8");
        expect_none("R9");
        idle(11 * C);

        // R7: candidate with line still low at the check is dropped
        send_pkt(32'h0033, 6); wait_done();
        reply_at(3 * C, 15'h0, 1'b1); idle(40);
        expect_pkt(16'h0033, 6, 1'b0, "R4");
        expect_none("R7");
        idle(11 * C);

        // R6/R7: edges one cycle either side of both window limits
        for (int j = 0; j < 4; j++) begin
            int k;
            bit in_win;
            k      = (j == 0) ? C : (j == 1) ? C + 1 : (j == 2) ? 10 * C : 10 * C + 1;
            in_win = (j == 1) || (j == 2);
            send_pkt(32'h003C, 8); wait_done();
            reply_at(k, 15'h7FFF, 1'b0); idle(10);
            expect_pkt(16'h003C, 8, 1'b0, "R4");
            if (in_win) expect_rpl(16'h7FFF, "R7");
            else        expect_pkt(16'h0000, 1, 1'b0, "R6");
            expect_none("R6");
            idle(11 * C);
        end

        idle(20);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule